// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit system control registers reached over a plain word-addressed bus: an address, a write strobe with write data, and a read strobe whose data returns on the next clock. A key word at address 0 unlocks the bank. While the bank is locked, writes to every other address are refused and flagged.

The bank contains several kinds of register:
- Reset and clock-stop registers that can only have bits set, each with a clear alias at the next word.
- Two strap registers. Each is loaded from input ports at reset and write-guarded by a protect word two addresses above it.
- Three PLL extension words that always read as locked.
- A read-only random word that steps a 32-bit LFSR on every read.
- Read-only revision and identification words.
- Ordinary read/write words.

All reset contents come from a packed parameter table. A one-cycle error pulse marks any refused write.

Top module: `keyed_ctrl_regs`

## Requirements
- R1: A write to word 0 stores 1 when the data equals UNLOCK_KEY and stores 0 for any other data. A read of word 0 returns that value, so any other data re-locks the bank.
- R2: While word 0 holds 0, a write to any in-range address above 0 pulses err_o. With STRICT=1 the write is discarded. Writes to word 0 are always accepted.
- R3: Words 4, 6, 8 and 10 are set-only: a write ORs the data into the stored value.
- R4: A write to word 5, 7, 9 or 11 clears, in the word one below, every bit that is 1 in the data. These clear aliases, and the strap clear aliases 13 and 17, read as 0.
- R5: The strap words 12 and 16 are guarded by the protect words 14 and 18. A strap write is ignored while its protect word is nonzero, and otherwise ORs the data in. A write to 13 or 17 clears bits of the strap word whether or not it is protected.
- R6: Reads of words 20, 21 and 22 return the stored value with bit 31 forced to 1.
- R7: Each read of word 24 returns the next state of the LFSR and advances it. The next state is (s >> 1) XOR (s[0] ? 32'h80200003 : 0), starting from SEED.
- R8: Writes to words 1, 2, 24, 26 and 27 leave them unchanged and pulse err_o.
- R9: Addresses at or above NREGS read as 0, change no register, and pulse err_o when written.
- R10: Reset loads each word i from RST_VALS[32*i +: 32]. The strap words then take strap_a_i and strap_b_i, word 0 takes PON_KEY, and rdata_o and err_o are cleared.
- R11: rdata_o and err_o are registered. They change one cycle after a request, err_o is low after a cycle with no write, and rdata_o holds between reads.
- R12: Any other in-range word (3, 14, 15, 18 to 23, 25, 28 to NREGS-1) stores the written data as is. A read in the same cycle as a write returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| err_o | output | 1 | One-cycle pulse for a refused write |
| strap_a_i | input | 32 | Reset value of strap word 12 |
| strap_b_i | input | 32 | Reset value of strap word 16 |

## Verification
Every result is due exactly one rising edge after the request that causes it. Read data, the error pulse and the new register contents all appear at that edge. A stored effect becomes visible through a read issued on any later cycle. The bench model updates its state at the same rising edge as the design. Both outputs are compared on the following falling edge, so each comparison lines up with the request issued one cycle earlier and carries that request's requirement tag.

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs #(
  parameter int          NREGS      = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] UNLOCK_KEY = 32'h5CA1_AB1E,
  parameter bit          STRICT     = 1'b1,
  parameter bit          PON_KEY    = 1'b0,
  parameter logic [31:0] SEED       = 32'hACE1_2468,
  parameter logic [NREGS*32-1:0] RST_VALS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic [31:0]       strap_a_i,
  input  logic [31:0]       strap_b_i
);
  localparam int DW = 32;
  localparam int IW = $clog2(NREGS);
  localparam logic [DW-1:0] TAPS = 32'h8020_0003;
  localparam logic [IW-1:0] A_KEY = IW'(0),  A_REV = IW'(1),  A_REV2 = IW'(2);
  localparam logic [IW-1:0] A_SET0 = IW'(4), A_SET1 = IW'(6), A_SET2 = IW'(8), A_SET3 = IW'(10);
  localparam logic [IW-1:0] A_STRA = IW'(12), A_PROA = IW'(14);
  localparam logic [IW-1:0] A_STRB = IW'(16), A_PROB = IW'(18);
  localparam logic [IW-1:0] A_PLL0 = IW'(20), A_PLL1 = IW'(21), A_PLL2 = IW'(22);
  localparam logic [IW-1:0] A_RNG = IW'(24), A_ID0 = IW'(26), A_ID1 = IW'(27);

  logic [DW-1:0] regs [NREGS];
  logic [DW-1:0] lfsr, lfsr_nxt, prot_word;
  logic [IW-1:0] idx, tgt;
  logic oob, blocked, is_set, is_clr, is_strap, is_pll, is_ro, is_rng, wr_ok, rd_zero;

  assign idx      = addr_i[IW-1:0];
  assign tgt      = idx - IW'(1);
  assign oob      = addr_i >= ADDR_W'(NREGS);
  assign is_set   = idx == A_SET0 || idx == A_SET1 || idx == A_SET2 || idx == A_SET3;
  assign is_clr   = idx == A_SET0 + IW'(1) || idx == A_SET1 + IW'(1) || idx == A_SET2 + IW'(1)
                 || idx == A_SET3 + IW'(1) || idx == A_STRA + IW'(1) || idx == A_STRB + IW'(1);
  assign is_strap = idx == A_STRA || idx == A_STRB;
  assign is_pll   = idx == A_PLL0 || idx == A_PLL1 || idx == A_PLL2;
  assign is_rng   = idx == A_RNG;
  assign is_ro    = idx == A_REV || idx == A_REV2 || is_rng || idx == A_ID0 || idx == A_ID1;
  assign blocked  = !regs[A_KEY][0] && idx != A_KEY;
  assign wr_ok    = wr_en_i && !oob && !is_ro && !(STRICT && blocked);
  assign prot_word = (idx == A_STRA) ? regs[A_PROA] : regs[A_PROB];
  assign lfsr_nxt = {1'b0, lfsr[DW-1:1]} ^ (lfsr[0] ? TAPS : '0);
  assign rd_zero  = oob || is_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= RST_VALS[i*DW +: DW];
      regs[A_STRA] <= strap_a_i;
      regs[A_STRB] <= strap_b_i;
      regs[A_KEY]  <= {31'b0, PON_KEY};
      lfsr    <= SEED;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= wr_en_i && (oob || is_ro || blocked);
      if (wr_ok) begin
        if (idx == A_KEY)  regs[A_KEY] <= {31'b0, wdata_i == UNLOCK_KEY};
        else if (is_set)   regs[idx] <= regs[idx] | wdata_i;
        else if (is_clr)   regs[tgt] <= regs[tgt] & ~wdata_i;
        else if (is_strap) begin
          if (prot_word == '0) regs[idx] <= regs[idx] | wdata_i;
        end
        else regs[idx] <= wdata_i;
      end
      if (rd_en_i) begin
        if (rd_zero)      rdata_o <= '0;
        else if (is_rng) begin
          rdata_o <= lfsr_nxt;
          lfsr    <= lfsr_nxt;
        end
        else if (is_pll)  rdata_o <= regs[idx] | 32'h8000_0000;
        else              rdata_o <= regs[idx];
      end
    end
  end

  p_key_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !oob && idx == A_KEY |=> regs[A_KEY][0] == $past(wdata_i == UNLOCK_KEY));
  p_locked_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !oob && blocked |=> err_o);
  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && idx == A_SET0 |=> (regs[A_SET0] & $past(wdata_i)) == $past(wdata_i));
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && idx == A_SET0 + IW'(1) |=> (regs[A_SET0] & $past(wdata_i)) == '0);
  p_pll_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !oob && is_pll |=> rdata_o[31]);
  p_rng_live_r7: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0);
  p_ro_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !oob && is_ro |=> err_o);
  p_oob_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && oob |=> err_o);
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && oob |=> rdata_o == '0);
  p_quiet_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !err_o);
  p_hold_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_keyed_ctrl_regs.sv
module tb_keyed_ctrl_regs;
  localparam int NR = 32;
  localparam int AW = 8;
  localparam logic [31:0] KEY  = 32'h5CA1_AB1E;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  localparam logic [31:0] SA = 32'h0000_00F0;
  localparam logic [31:0] SB = 32'h1200_0001;

  function automatic logic [NR*32-1:0] mk_tbl();
    logic [NR*32-1:0] t;
    for (int i = 0; i < NR; i++) t[i*32 +: 32] = (32'h0101_0101 * 32'(i)) ^ 32'hC3A5_0F00;
    return t;
  endfunction
  localparam logic [NR*32-1:0] TBL = mk_tbl();

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic err;
  int checks = 0, fails = 0;
  bit started = 1'b0;
  string cur_tag = "R10", tag_q = "R10";

  always #10 clk = ~clk;

  keyed_ctrl_regs #(.NREGS(NR), .ADDR_W(AW), .UNLOCK_KEY(KEY), .STRICT(1'b1),
                    .PON_KEY(1'b0), .SEED(SEED), .RST_VALS(TBL)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .err_o(err), .strap_a_i(SA), .strap_b_i(SB));

  logic [31:0] m [NR];
  logic [31:0] m_rd, m_lfsr;
  logic m_err;

  always @(posedge clk) begin
    int a;
    started = 1'b1;
    tag_q = cur_tag;
    a = int'(addr);
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) m[i] = TBL[i*32 +: 32];
      m[12] = SA; m[16] = SB; m[0] = 32'd0;
      m_lfsr = SEED; m_rd = '0; m_err = 1'b0;
    end else begin
      if (rd_en) begin
        if (a >= NR || a inside {5, 7, 9, 11, 13, 17}) m_rd = '0;
        else if (a == 24) begin
          m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h8020_0003 : 32'h0);
          m_rd = m_lfsr;
        end
        else if (a inside {20, 21, 22}) m_rd = m[a] | 32'h8000_0000;
        else m_rd = m[a];
      end
      m_err = 1'b0;
      if (wr_en) begin
        if (a >= NR || a inside {1, 2, 24, 26, 27}) m_err = 1'b1;
        else if (m[0] == 0 && a != 0) m_err = 1'b1;
        else if (a == 0) m[0] = (wdata == KEY) ? 32'd1 : 32'd0;
        else if (a inside {4, 6, 8, 10}) m[a] = m[a] | wdata;
        else if (a inside {5, 7, 9, 11, 13, 17}) m[a-1] = m[a-1] & ~wdata;
        else if (a inside {12, 16}) begin
          if (m[a+2] == 0) m[a] = m[a] | wdata;
        end
        else m[a] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", tag_q, rdata, m_rd);
      end
      checks++;
      if (err !== m_err) begin
        fails++;
        $display("FAIL %s err actual=%b expected=%b", tag_q, err, m_err);
      end
    end
  end

  task automatic op(input logic w, input logic r, input int a, input logic [31:0] d, input string t);
    @(negedge clk);
    #1;
    cur_tag = t; wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
  endtask
  task automatic wr(input int a, input logic [31:0] d, input string t); op(1'b1, 1'b0, a, d, t); endtask
  task automatic rd(input int a, input string t); op(1'b0, 1'b1, a, '0, t); endtask
  task automatic idle(input string t); op(1'b0, 1'b0, 0, '0, t); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NR; i++) rd(i, "R10");
    idle("R11"); idle("R11");
    wr(30, 32'hDEAD_BEEF, "R2"); rd(30, "R2");
    wr(4, 32'hFFFF_FFFF, "R2"); rd(4, "R2");
    wr(14, 32'h0, "R2"); rd(14, "R2");
    wr(0, 32'h0000_1234, "R1"); rd(0, "R1");
    wr(0, KEY, "R1"); rd(0, "R1");
    wr(30, 32'h1357_9BDF, "R12"); rd(30, "R12");
    wr(31, 32'h0F0F_0000, "R12"); rd(31, "R12");
    op(1'b1, 1'b1, 3, 32'hAAAA_5555, "R12"); rd(3, "R12");
    wr(4, 32'h3000_0003, "R3"); rd(4, "R3");
    wr(8, 32'h0000_F00F, "R3"); rd(8, "R3");
    wr(5, 32'hFFFF_0000, "R4"); rd(4, "R4"); rd(5, "R4");
    wr(11, 32'hFFFF_FFFF, "R4"); rd(10, "R4");
    rd(12, "R5"); wr(12, 32'h0000_000F, "R5"); rd(12, "R5");
    wr(14, 32'h0, "R5"); wr(12, 32'h0000_0F00, "R5"); rd(12, "R5");
    wr(13, 32'h0000_00F0, "R5"); rd(12, "R5"); rd(13, "R5");
    wr(17, 32'h1000_0000, "R5"); rd(16, "R5");
    wr(16, 32'h0000_FF00, "R5"); rd(16, "R5");
    wr(20, 32'h0, "R6"); rd(20, "R6"); rd(21, "R6"); rd(22, "R6");
    for (int i = 0; i < 4; i++) rd(24, "R7");
    idle("R11"); rd(24, "R7");
    wr(1, 32'h1111_1111, "R8"); rd(1, "R8");
    wr(24, 32'h0, "R8"); wr(26, 32'h0, "R8"); rd(26, "R8");
    wr(27, 32'hFFFF_FFFF, "R8"); rd(27, "R8"); wr(2, 32'h5, "R8"); rd(2, "R8");
    rd(40, "R9"); wr(40, 32'h7777_7777, "R9"); rd(8, "R9");
    wr(200, 32'h1234_5678, "R9"); rd(255, "R9"); rd(8, "R9");
    wr(0, 32'h0, "R1"); rd(0, "R1");
    wr(4, 32'h0000_0000, "R2"); wr(5, 32'hFFFF_FFFF, "R2"); rd(4, "R2");
    idle("R11"); idle("R11");
    summary();
  end
endmodule